// File: doc/BRIEF.md
# Systolic Array Tile Allocator

This block takes a request to run one matrix operation on part of a square array of processing elements, 128 by 128 by default. It checks that the request is legal and turns it into two enable masks: one bit per PE row and one bit per PE column. A request gives a start position and a tile size for each axis, the partition and free extents of the stationary operand, the partition extent of the moving operand, and a flag for the double-row performance mode. A tiling-enable input tells the block that a position and a size were supplied. When it is low, the request uses the whole array.

A tile may span the full array, half of it, or a quarter of it on each axis. The row and column sizes are chosen independently. A build parameter can remove the quarter size. A legal request sets the row bits from its row start up to, but not including, row start plus row size, and sets the column bits in the same way. An illegal request returns a nonzero error code and two all-zero masks. All outputs are registered and appear one clock after the request strobe. They keep their values until the next request.

Top module: `tile_alloc`

## Requirements
- R1: After reset, `out_vld` is 0, `err_code` is 0 and both masks are all zero.
- R2: `out_vld` is 1 in the cycle after the cycle in which `req_vld` is 1, and 0 in every other cycle. Masks and `err_code` change only when a request is taken.
- R3: When `tile_en` is 0, the block ignores the start and size inputs. It uses start 0 and size DIM on both axes, so a legal request gives two masks of all ones.
- R4: On each axis the size must be DIM, DIM/2, or DIM/4. DIM/4 is allowed only when QUARTER_EN is 1. Any other size gives error code 1 (illegal size).
- R5: If `dbl_row` is 1 and the effective column size is less than DIM, the block gives error code 2 (mode conflict).
- R6: If a start is not a whole multiple of its axis size, the block gives error code 3 (misaligned).
- R7: If start plus size is greater than DIM on either axis, the block gives error code 4 (out of range).
- R8: If `stat_part` is greater than the row size, or `stat_free` is greater than the column size, the block gives error code 5 (operand overflow).
- R9: If `stat_part` differs from `mov_part`, the block gives error code 5.
- R10: When several errors apply, the lowest code wins. The order is 1, then 2, then 3, then 4, then 5.
- R11: For any nonzero error code, both masks are zero.
- R12: For a legal request, `err_code` is 0. Row mask bit i is 1 exactly when row_start <= i < row_start+row_size, and the column mask follows the same rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Request strobe |
| tile_en | input | 1 | Position and size supplied; use tiling |
| row_start | input | 8 | First PE row of the tile |
| col_start | input | 8 | First PE column of the tile |
| row_size | input | 8 | Row extent of the tile |
| col_size | input | 8 | Column extent of the tile |
| stat_part | input | 8 | Stationary operand partition extent |
| stat_free | input | 8 | Stationary operand free extent |
| mov_part | input | 8 | Moving operand partition extent |
| dbl_row | input | 1 | Double-row performance mode |
| row_mask | output | 128 | Enabled PE rows |
| col_mask | output | 128 | Enabled PE columns |
| out_vld | output | 1 | Result valid, one cycle after request |
| err_code | output | 3 | 0 legal, 1 size, 2 mode, 3 align, 4 range, 5 operand |

## Verification
The main overlap is between geometry checks and mask generation. One request can be misaligned on one axis, out of range on the other, and also in conflict with double-row mode. Only one code may be reported, and both masks must still be cleared. The bench sweeps a grid of starts, sizes and the mode flag on both axes, so many requests hit several faults at once. For each request, the bench works out the winning code from the priority order and rebuilds both masks from the interval rule.

// File: rtl/tile_alloc_pkg.sv
package tile_alloc_pkg;

  typedef enum logic [2:0] {
    TA_OK        = 3'd0,
    TA_BAD_SIZE  = 3'd1,
    TA_MODE      = 3'd2,
    TA_MISALIGN  = 3'd3,
    TA_RANGE     = 3'd4,
    TA_OPERAND   = 3'd5
  } ta_err_e;

  // legal slice widths: full, half, optional quarter
  function automatic bit size_is_legal(int sz, int dim, bit quarter);
    return (sz == dim) || (sz == dim / 2) || (quarter && (sz == dim / 4));
  endfunction

  // power-of-two size: low bits of start must be clear
  function automatic bit is_aligned(int start, int sz);
    return (sz != 0) && ((start & (sz - 1)) == 0);
  endfunction

  function automatic bit fits_in(int start, int sz, int dim);
    return (start + sz) <= dim;
  endfunction

  function automatic bit in_tile(int idx, int start, int sz);
    return (idx >= start) && (idx < start + sz);
  endfunction

endpackage

// File: rtl/ta_size_chk.sv
module ta_size_chk
  import tile_alloc_pkg::*;
#(
  parameter int DIM        = 128,
  parameter bit QUARTER_EN = 1'b1,
  parameter int SW         = 8
) (
  input  logic          tile_en,
  input  logic [SW-1:0] row_size_i,
  input  logic [SW-1:0] col_size_i,
  input  logic          dbl_row,
  output logic [SW-1:0] eff_row_size,
  output logic [SW-1:0] eff_col_size,
  output logic          size_bad,
  output logic          mode_bad
);
  localparam logic [SW-1:0] FULL = SW'(DIM);

  logic row_ok, col_ok;

  assign eff_row_size = tile_en ? row_size_i : FULL;
  assign eff_col_size = tile_en ? col_size_i : FULL;
  assign row_ok   = size_is_legal(int'(eff_row_size), DIM, QUARTER_EN);
  assign col_ok   = size_is_legal(int'(eff_col_size), DIM, QUARTER_EN);
  assign size_bad = !(row_ok && col_ok);
  assign mode_bad = dbl_row && (eff_col_size != FULL);
endmodule

// File: rtl/ta_place_chk.sv
module ta_place_chk
  import tile_alloc_pkg::*;
#(
  parameter int DIM = 128,
  parameter int SW  = 8
) (
  input  logic [SW-1:0] start,
  input  logic [SW-1:0] size,
  output logic          misalign,
  output logic          out_of_range
);
  assign misalign     = !is_aligned(int'(start), int'(size));
  assign out_of_range = !fits_in(int'(start), int'(size), DIM);
endmodule

// File: rtl/ta_mask_gen.sv
module ta_mask_gen
  import tile_alloc_pkg::*;
#(
  parameter int DIM = 128,
  parameter int SW  = 8
) (
  input  logic [SW-1:0]  start,
  input  logic [SW-1:0]  size,
  output logic [DIM-1:0] mask
);
  for (genvar i = 0; i < DIM; i++) begin : g_bit
    assign mask[i] = in_tile(i, int'(start), int'(size));
  end
endmodule

// File: rtl/tile_alloc.sv
module tile_alloc
  import tile_alloc_pkg::*;
#(
  parameter int DIM        = 128,
  parameter bit QUARTER_EN = 1'b1,
  localparam int SW        = $clog2(DIM) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_vld,
  input  logic           tile_en,
  input  logic [SW-1:0]  row_start,
  input  logic [SW-1:0]  col_start,
  input  logic [SW-1:0]  row_size,
  input  logic [SW-1:0]  col_size,
  input  logic [SW-1:0]  stat_part,
  input  logic [SW-1:0]  stat_free,
  input  logic [SW-1:0]  mov_part,
  input  logic           dbl_row,
  output logic [DIM-1:0] row_mask,
  output logic [DIM-1:0] col_mask,
  output logic           out_vld,
  output logic [2:0]     err_code
);
  // effective geometry
  logic [SW-1:0]  eff_rs, eff_cs, eff_rz, eff_cz;
  // named fault events
  logic           ev_size, ev_mode, ev_operand;
  logic           ev_row_mis, ev_col_mis, ev_row_oor, ev_col_oor;
  logic [DIM-1:0] row_m, col_m;
  ta_err_e        err_d, err_q;

  assign eff_rs = tile_en ? row_start : '0;
  assign eff_cs = tile_en ? col_start : '0;

  ta_size_chk #(.DIM(DIM), .QUARTER_EN(QUARTER_EN), .SW(SW)) u_size (
    .tile_en(tile_en), .row_size_i(row_size), .col_size_i(col_size),
    .dbl_row(dbl_row), .eff_row_size(eff_rz), .eff_col_size(eff_cz),
    .size_bad(ev_size), .mode_bad(ev_mode)
  );

  ta_place_chk #(.DIM(DIM), .SW(SW)) u_row_place (
    .start(eff_rs), .size(eff_rz), .misalign(ev_row_mis), .out_of_range(ev_row_oor)
  );

  ta_place_chk #(.DIM(DIM), .SW(SW)) u_col_place (
    .start(eff_cs), .size(eff_cz), .misalign(ev_col_mis), .out_of_range(ev_col_oor)
  );

  ta_mask_gen #(.DIM(DIM), .SW(SW)) u_row_mask (
    .start(eff_rs), .size(eff_rz), .mask(row_m)
  );

  ta_mask_gen #(.DIM(DIM), .SW(SW)) u_col_mask (
    .start(eff_cs), .size(eff_cz), .mask(col_m)
  );

  assign ev_operand = (stat_part > eff_rz) || (stat_free > eff_cz) ||
                      (stat_part != mov_part);

  // fixed priority: size, mode, alignment, range, operand
  always_comb begin
    if (ev_size)                       err_d = TA_BAD_SIZE;
    else if (ev_mode)                  err_d = TA_MODE;
    else if (ev_row_mis || ev_col_mis) err_d = TA_MISALIGN;
    else if (ev_row_oor || ev_col_oor) err_d = TA_RANGE;
    else if (ev_operand)               err_d = TA_OPERAND;
    else                               err_d = TA_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      err_q    <= TA_OK;
      row_mask <= '0;
      col_mask <= '0;
    end else begin
      out_vld <= req_vld;
      if (req_vld) begin
        err_q    <= err_d;
        row_mask <= (err_d == TA_OK) ? row_m : '0;
        col_mask <= (err_d == TA_OK) ? col_m : '0;
      end
    end
  end

  assign err_code = err_q;

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> out_vld); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !out_vld && $stable(row_mask) && $stable(err_code)); // R2
  AST_ERR_CLEARS_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && err_code != 3'd0) |-> (row_mask == '0 && col_mask == '0)); // R11
  AST_LEGAL_ROW_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && err_code == 3'd0) |->
      ($countones(row_mask) == DIM || $countones(row_mask) == DIM/2 ||
       (QUARTER_EN && $countones(row_mask) == DIM/4))); // R12
  AST_DBL_FULL_COLS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && err_code == 3'd0 && $past(dbl_row)) |-> (&col_mask)); // R5
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (err_code <= 3'd5)); // R10
endmodule

// File: tb/tile_alloc_test.sv
module tile_alloc_test;
  localparam int DIM = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_vld = 1'b0, tile_en = 1'b0, dbl_row = 1'b0;
  logic [7:0] row_start = '0, col_start = '0, row_size = '0, col_size = '0;
  logic [7:0] stat_part = '0, stat_free = '0, mov_part = '0;
  logic [DIM-1:0] row_mask, col_mask;
  logic out_vld;
  logic [2:0] err_code;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tile_alloc uut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .tile_en(tile_en),
    .row_start(row_start), .col_start(col_start), .row_size(row_size),
    .col_size(col_size), .stat_part(stat_part), .stat_free(stat_free),
    .mov_part(mov_part), .dbl_row(dbl_row), .row_mask(row_mask),
    .col_mask(col_mask), .out_vld(out_vld), .err_code(err_code)
  );

  task automatic check(string tag, logic [DIM-1:0] act, logic [DIM-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string code_tag(int c);
    case (c)
      0: return "R12";
      1: return "R4 R10";
      2: return "R5 R10";
      3: return "R6 R10";
      4: return "R7 R10";
      default: return "R8/R9";
    endcase
  endfunction

  function automatic int model_err(bit te, int rs, int rz, int cs, int cz,
                                   int sp, int sf, int mp, bit dbl);
    bit okr, okc;
    if (!te) begin rs = 0; cs = 0; rz = DIM; cz = DIM; end
    okr = (rz == 128) || (rz == 64) || (rz == 32);
    okc = (cz == 128) || (cz == 64) || (cz == 32);
    if (!(okr && okc)) return 1;
    if (dbl && cz < DIM) return 2;
    if ((rs % rz) != 0 || (cs % cz) != 0) return 3;
    if (rs + rz > DIM || cs + cz > DIM) return 4;
    if (sp > rz || sf > cz || sp != mp) return 5;
    return 0;
  endfunction

  function automatic logic [DIM-1:0] model_mask(int s, int z);
    logic [DIM-1:0] m = '0;
    for (int i = 0; i < DIM; i++) if (i >= s && i < s + z) m[i] = 1'b1;
    return m;
  endfunction

  task automatic run_req(bit te, int rs, int rz, int cs, int cz,
                         int sp, int sf, int mp, bit dbl);
    int e;
    logic [DIM-1:0] er, ec;
    @(negedge clk);
    tile_en = te; row_start = 8'(rs); row_size = 8'(rz);
    col_start = 8'(cs); col_size = 8'(cz); stat_part = 8'(sp);
    stat_free = 8'(sf); mov_part = 8'(mp); dbl_row = dbl; req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
    e = model_err(te, rs, rz, cs, cz, sp, sf, mp, dbl);
    if (e == 0) begin
      er = te ? model_mask(rs, rz) : model_mask(0, DIM);
      ec = te ? model_mask(cs, cz) : model_mask(0, DIM);
    end else begin
      er = '0; ec = '0;
    end
    check("R2 vld", DIM'(out_vld), DIM'(1));
    check(code_tag(e), DIM'(err_code), DIM'(e));
    check(e == 0 ? (te ? "R12 row" : "R3 row") : "R11 row", row_mask, er);
    check(e == 0 ? (te ? "R12 col" : "R3 col") : "R11 col", col_mask, ec);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int starts[9] = '{0, 16, 32, 48, 64, 80, 96, 112, 128};
    int sizes[5]  = '{16, 32, 64, 128, 200};
    logic [DIM-1:0] hold_r;
    logic [2:0] hold_e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 vld", DIM'(out_vld), '0);
    check("R1 err", DIM'(err_code), '0);
    check("R1 row", row_mask, '0);
    check("R1 col", col_mask, '0);

    // geometry sweep with several faults per request (R4..R7, R10..R12)
    for (int a = 0; a < 9; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 9; c++)
          for (int d = 0; d < 5; d++)
            for (int m = 0; m < 2; m++)
              run_req(1'b1, starts[a], sizes[b], starts[c], sizes[d],
                      16, 16, 16, m[0]);

    // worked case: bottom half rows, all columns
    run_req(1'b1, 64, 64, 0, 128, 64, 128, 64, 1'b0);

    // R3: tiling off ignores position and size
    run_req(1'b0, 17, 5, 99, 3, 128, 128, 128, 1'b1);
    run_req(1'b0, 64, 64, 64, 64, 100, 20, 100, 1'b0);

    // operand sweep (R8, R9)
    for (int p = 0; p < 5; p++)
      for (int f = 0; f < 4; f++)
        for (int k = 0; k < 2; k++) begin
          int pv[5] = '{0, 32, 64, 65, 128};
          int fv[4] = '{0, 31, 32, 33};
          run_req(1'b1, 64, 64, 32, 32, pv[p], fv[f], pv[p] + k, 1'b0);
        end

    // R2: idle cycle keeps results, no strobe
    run_req(1'b1, 32, 32, 96, 32, 8, 8, 8, 1'b0);
    hold_r = row_mask; hold_e = err_code;
    @(negedge clk);
    row_start = 8'd0; row_size = 8'd128;
    @(negedge clk);
    check("R2 idle vld", DIM'(out_vld), '0);
    check("R2 hold row", row_mask, hold_r);
    check("R2 hold err", DIM'(err_code), DIM'(hold_e));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule